// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block stands between a host block port and an array of N+1 block stores. The array keeps one parity block for every N data blocks. Each store is reached through a simple request/acknowledge word port. A host write of one data block runs as a read-modify-write sequence. The engine first fetches the old contents of the target data block and of the matching parity block. It then stores the new data block, followed by a parity block that is updated incrementally. The parity update uses only the old data, the old parity and the new data, so the other data disks of the stripe are never touched.

A logical block number maps to a stripe row and a position inside that stripe. The parity position moves from one stripe to the next, so every disk carries part of the parity load. A host read of one block reads only the data disk that holds the block.

Blocks pass through the disk ports one word at a time, and parity is formed word by word. The host sees a busy flag while a request is in progress. At the end it sees a one-cycle done pulse, together with an error flag that tells whether a disk reported a fault.

Top module: `raid5_small_write`

## Requirements
- R1: The stripe row of logical block L is L / N_DATA. Its position inside the stripe is k = L mod N_DATA. The row is driven on `dk_row` for every access of the request.
- R2: The parity disk of stripe row s is p = N_DATA - (s mod (N_DATA+1)). The data disk is k when k < p, and k+1 otherwise. A disk with index d is driven through bit d of `dk_req`.
- R3: A write makes exactly 4*BLK_WORDS disk accesses, in this order: read every old data word, read every old parity word, write every new data word, write every new parity word. Words go in ascending index order within each phase. No write is issued before both reads have finished.
- R4: Each new parity word is the bitwise XOR of the old parity word, the old data word and the new data word. After a write, the XOR of all N_DATA+1 disks over any row and word is unchanged.
- R5: A read makes exactly BLK_WORDS read accesses, all to the mapped data disk. It returns the block on `host_rdata`, with word i in bits [i*WORD_W +: WORD_W].
- R6: At most one disk request line is high at any time. While a request waits for its acknowledge, its disk, direction, row, word index and write data stay unchanged.
- R7: A request is taken when `host_req` is high while `host_busy` is low. `host_busy` is high from the cycle after acceptance until completion. A `host_req` pulse seen while busy has no effect.
- R8: Completion raises `host_done` for exactly one cycle. On success `host_err` is 0 in that cycle.
- R9: If an acknowledged access has its disk error bit set, the sequence stops at once. `host_done` rises with `host_err` = 1, and no further disk access is issued.
- R10: After reset, `host_busy`, `host_done` and all `dk_req` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Start a block operation |
| host_we | input | 1 | 1 = write block, 0 = read block |
| host_lba | input | LBA_W | Logical block number |
| host_wdata | input | BLK_WORDS*WORD_W | Block to write, word i in bits [i*WORD_W +: WORD_W] |
| host_busy | output | 1 | Operation in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Completion ended by a disk error |
| host_rdata | output | BLK_WORDS*WORD_W | Block returned by a read |
| dk_req | output | N_DATA+1 | Per-disk word request |
| dk_we | output | 1 | Direction of the pending access, 1 = write |
| dk_row | output | LBA_W | Stripe row of the pending access |
| dk_widx | output | $clog2(BLK_WORDS) | Word index within the block |
| dk_wdata | output | WORD_W | Write word |
| dk_ack | input | N_DATA+1 | Per-disk acknowledge, one cycle per access |
| dk_err | input | N_DATA+1 | Per-disk fault, valid with acknowledge |
| dk_rdata | input | (N_DATA+1)*WORD_W | Per-disk read word, valid with acknowledge |

## Verification
Writes are aimed at six consecutive stripe rows, which takes the parity position through every disk and wraps it once. Each write is checked against the ordered access list predicted for its own row. This tells a wrong rotation or a wrong data-disk skip apart from a wrong phase order. The disk models stall in a pattern that shifts from disk to disk, so the hold-until-acknowledge rule is exercised, and so are back-to-back acknowledges. Further patterns show different faults: repeated writes to a single block catch stale parity buffers, a read after the writes catches a parity disk being touched, a request pulsed while busy must leave the access stream unchanged, and a fault injected on the parity read must stop the sequence before any write.

// File: rtl/r5_pkg.sv
package r5_pkg;

    // Phase of the block sequencer; the read-modify-write order depends on it.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RD_DAT = 3'd1,
        PH_RD_PAR = 3'd2,
        PH_WR_DAT = 3'd3,
        PH_WR_PAR = 3'd4
    } r5_phase_e;

endpackage

// File: rtl/r5_stripe_map.sv
module r5_stripe_map #(
    parameter int N_DATA = 4,
    parameter int LBA_W  = 12,
    localparam int N_DISK = N_DATA + 1,
    localparam int DISK_W = $clog2(N_DISK)
) (
    input  logic [LBA_W-1:0]  lba_i,
    output logic [LBA_W-1:0]  row_o,
    output logic [DISK_W-1:0] dat_disk_o,
    output logic [DISK_W-1:0] par_disk_o
);

    logic [LBA_W-1:0] stripe_d, slot_d, rot_d, par_full_d, dat_full_d;

    always_comb begin
        stripe_d   = lba_i / LBA_W'(N_DATA);
        slot_d     = lba_i % LBA_W'(N_DATA);
        rot_d      = stripe_d % LBA_W'(N_DISK);
        par_full_d = LBA_W'(N_DATA) - rot_d;
        dat_full_d = (slot_d < par_full_d) ? slot_d : slot_d + 1'b1;
        row_o      = stripe_d;
        par_disk_o = DISK_W'(par_full_d);
        dat_disk_o = DISK_W'(dat_full_d);
        // R2: the data block never lands on the parity position of its row
        p_map_split_r2: assert (par_full_d != dat_full_d);
        // R2: both positions are inside the array
        p_map_range_r2: assert ((par_full_d < LBA_W'(N_DISK)) && (dat_full_d < LBA_W'(N_DISK)));
    end

endmodule

// File: rtl/r5_disk_mux.sv
module r5_disk_mux #(
    parameter int N_DISK = 5,
    parameter int WORD_W = 16,
    localparam int DISK_W = $clog2(N_DISK)
) (
    input  logic [DISK_W-1:0]        sel_i,
    input  logic                     req_i,
    output logic [N_DISK-1:0]        dk_req_o,
    input  logic [N_DISK-1:0]        dk_ack_i,
    input  logic [N_DISK-1:0]        dk_err_i,
    input  logic [N_DISK*WORD_W-1:0] dk_rdata_i,
    output logic                     ack_o,
    output logic                     err_o,
    output logic [WORD_W-1:0]        rdata_o
);

    for (genvar g = 0; g < N_DISK; g++) begin : g_req
        assign dk_req_o[g] = req_i && (sel_i == DISK_W'(g));
    end

    always_comb begin
        ack_o   = 1'b0;
        err_o   = 1'b0;
        rdata_o = '0;
        for (int i = 0; i < N_DISK; i++) begin
            if (sel_i == DISK_W'(i)) begin
                ack_o   = dk_ack_i[i];
                err_o   = dk_err_i[i];
                rdata_o = dk_rdata_i[i*WORD_W +: WORD_W];
            end
        end
        // R6: a pending request always addresses an existing disk
        p_sel_range_r6: assert (!req_i || (int'(sel_i) < N_DISK));
    end

endmodule

// File: rtl/r5_seq.sv
module r5_seq
    import r5_pkg::*;
#(
    parameter int N_DATA    = 4,
    parameter int WORD_W    = 16,
    parameter int BLK_WORDS = 4,
    parameter int LBA_W     = 12,
    localparam int N_DISK = N_DATA + 1,
    localparam int DISK_W = $clog2(N_DISK),
    localparam int WIDX_W = $clog2(BLK_WORDS),
    localparam int BLK_W  = WORD_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [LBA_W-1:0]  host_lba_i,
    input  logic [BLK_W-1:0]  host_wdata_i,
    output logic              host_busy_o,
    output logic              host_done_o,
    output logic              host_err_o,
    output logic [BLK_W-1:0]  host_rdata_o,
    output logic [LBA_W-1:0]  lba_o,
    input  logic [DISK_W-1:0] dat_disk_i,
    input  logic [DISK_W-1:0] par_disk_i,
    output logic              req_o,
    output logic [DISK_W-1:0] sel_o,
    output logic              we_o,
    output logic [WIDX_W-1:0] widx_o,
    output logic [WORD_W-1:0] wdata_o,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic [WORD_W-1:0] rdata_i
);

    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(BLK_WORDS - 1);

    typedef struct packed {
        r5_phase_e         phase;
        logic              is_wr;
        logic [LBA_W-1:0]  lba;
        logic [WIDX_W-1:0] widx;
        logic [BLK_W-1:0]  old_dat;
        logic [BLK_W-1:0]  old_par;
        logic [BLK_W-1:0]  new_dat;
        logic              done;
        logic              err;
    } seq_t;

    seq_t st_q, st_d;

    // Sequencer next state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (host_req_i) begin
                st_d.phase   = PH_RD_DAT;
                st_d.is_wr   = host_we_i;
                st_d.lba     = host_lba_i;
                st_d.new_dat = host_wdata_i;
                st_d.widx    = '0;
            end
        end else if (ack_i) begin
            if (err_i) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.err   = 1'b1;
                st_d.widx  = '0;
            end else begin
                if (st_q.phase == PH_RD_DAT) begin
                    st_d.old_dat[st_q.widx*WORD_W +: WORD_W] = rdata_i;
                end
                if (st_q.phase == PH_RD_PAR) begin
                    st_d.old_par[st_q.widx*WORD_W +: WORD_W] = rdata_i;
                end
                if (st_q.widx == LAST_WORD) begin
                    st_d.widx = '0;
                    unique case (st_q.phase)
                        PH_RD_DAT: begin
                            if (st_q.is_wr) begin
                                st_d.phase = PH_RD_PAR;
                            end else begin
                                st_d.phase = PH_IDLE;
                                st_d.done  = 1'b1;
                            end
                        end
                        PH_RD_PAR: st_d.phase = PH_WR_DAT;
                        PH_WR_DAT: st_d.phase = PH_WR_PAR;
                        default: begin
                            st_d.phase = PH_IDLE;
                            st_d.done  = 1'b1;
                        end
                    endcase
                end else begin
                    st_d.widx = st_q.widx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Disk-side drive
    always_comb begin
        req_o  = (st_q.phase != PH_IDLE);
        we_o   = (st_q.phase == PH_WR_DAT) || (st_q.phase == PH_WR_PAR);
        sel_o  = ((st_q.phase == PH_RD_PAR) || (st_q.phase == PH_WR_PAR)) ? par_disk_i : dat_disk_i;
        widx_o = st_q.widx;
        if (st_q.phase == PH_WR_PAR) begin
            wdata_o = st_q.old_par[st_q.widx*WORD_W +: WORD_W]
                    ^ st_q.old_dat[st_q.widx*WORD_W +: WORD_W]
                    ^ st_q.new_dat[st_q.widx*WORD_W +: WORD_W];
        end else begin
            wdata_o = st_q.new_dat[st_q.widx*WORD_W +: WORD_W];
        end
    end

    assign lba_o        = st_q.lba;
    assign host_busy_o  = (st_q.phase != PH_IDLE);
    assign host_done_o  = st_q.done;
    assign host_err_o   = st_q.err;
    assign host_rdata_o = st_q.old_dat;

    // R6: a request waiting for its acknowledge keeps every field
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(sel_o) && $stable(we_o) && $stable(widx_o)
                                && $stable(wdata_o) && $stable(lba_o)));

    // R9: a faulted acknowledge ends the request at the next cycle
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && err_i) |=> (host_done_o && host_err_o && !req_o));

    // R8: the completion pulse lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done_o |=> !host_done_o);

    // R7: the captured block number cannot change while busy
    p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy_o |=> (!host_busy_o || $stable(lba_o)));

    // R3: a write on a disk is only ever the direct follow-up of another access
    p_write_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && we_o) |-> $past(req_o));

endmodule

// File: rtl/raid5_small_write.sv
module raid5_small_write #(
    parameter int N_DATA    = 4,
    parameter int WORD_W    = 16,
    parameter int BLK_WORDS = 4,
    parameter int LBA_W     = 12,
    localparam int N_DISK = N_DATA + 1,
    localparam int DISK_W = $clog2(N_DISK),
    localparam int WIDX_W = $clog2(BLK_WORDS),
    localparam int BLK_W  = WORD_W * BLK_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [LBA_W-1:0]         host_lba,
    input  logic [BLK_W-1:0]         host_wdata,
    output logic                     host_busy,
    output logic                     host_done,
    output logic                     host_err,
    output logic [BLK_W-1:0]         host_rdata,
    output logic [N_DISK-1:0]        dk_req,
    output logic                     dk_we,
    output logic [LBA_W-1:0]         dk_row,
    output logic [WIDX_W-1:0]        dk_widx,
    output logic [WORD_W-1:0]        dk_wdata,
    input  logic [N_DISK-1:0]        dk_ack,
    input  logic [N_DISK-1:0]        dk_err,
    input  logic [N_DISK*WORD_W-1:0] dk_rdata
);

    logic [LBA_W-1:0]  lba_q;
    logic [DISK_W-1:0] dat_disk, par_disk, sel;
    logic              req, ack, err;
    logic [WORD_W-1:0] rdata;

    r5_stripe_map #(.N_DATA(N_DATA), .LBA_W(LBA_W)) u_map (
        .lba_i      (lba_q),
        .row_o      (dk_row),
        .dat_disk_o (dat_disk),
        .par_disk_o (par_disk)
    );

    r5_seq #(.N_DATA(N_DATA), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .LBA_W(LBA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req_i   (host_req),
        .host_we_i    (host_we),
        .host_lba_i   (host_lba),
        .host_wdata_i (host_wdata),
        .host_busy_o  (host_busy),
        .host_done_o  (host_done),
        .host_err_o   (host_err),
        .host_rdata_o (host_rdata),
        .lba_o        (lba_q),
        .dat_disk_i   (dat_disk),
        .par_disk_i   (par_disk),
        .req_o        (req),
        .sel_o        (sel),
        .we_o         (dk_we),
        .widx_o       (dk_widx),
        .wdata_o      (dk_wdata),
        .ack_i        (ack),
        .err_i        (err),
        .rdata_i      (rdata)
    );

    r5_disk_mux #(.N_DISK(N_DISK), .WORD_W(WORD_W)) u_mux (
        .sel_i      (sel),
        .req_i      (req),
        .dk_req_o   (dk_req),
        .dk_ack_i   (dk_ack),
        .dk_err_i   (dk_err),
        .dk_rdata_i (dk_rdata),
        .ack_o      (ack),
        .err_o      (err),
        .rdata_o    (rdata)
    );

    // R6: never more than one disk addressed at once
    p_one_disk_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dk_req));

    // R10: nothing requested in the cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dk_req == '0));

endmodule

// File: tb/tb_raid5_small_write.sv
module tb_raid5_small_write;

    localparam int ND = 4;
    localparam int NK = ND + 1;
    localparam int W  = 16;
    localparam int BW = 4;
    localparam int LW = 12;
    localparam int ROWS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0;
    logic host_we = 1'b0;
    logic [LW-1:0] host_lba = '0;
    logic [BW*W-1:0] host_wdata = '0;
    logic host_busy, host_done, host_err;
    logic [BW*W-1:0] host_rdata;
    logic [NK-1:0] dk_req;
    logic dk_we;
    logic [LW-1:0] dk_row;
    logic [1:0] dk_widx;
    logic [W-1:0] dk_wdata;
    logic [NK-1:0] dk_ack = '0;
    logic [NK-1:0] dk_err = '0;
    logic [NK*W-1:0] dk_rdata = '0;

    always #5 clk = ~clk;

    raid5_small_write #(.N_DATA(ND), .WORD_W(W), .BLK_WORDS(BW), .LBA_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_lba(host_lba), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
        .dk_req(dk_req), .dk_we(dk_we), .dk_row(dk_row), .dk_widx(dk_widx),
        .dk_wdata(dk_wdata), .dk_ack(dk_ack), .dk_err(dk_err), .dk_rdata(dk_rdata)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Block stores modelled behaviourally
    logic [W-1:0] mem [NK][ROWS][BW];
    int inj_disk = -1;
    logic [7:0] cyc = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1'b1;
        for (int d = 0; d < NK; d++) begin
            if (!rst_n) begin
                dk_ack[d] <= 1'b0;
                dk_err[d] <= 1'b0;
            end else if (dk_req[d] && !dk_ack[d] && ((int'(cyc) + d) % 3 != 1)) begin
                dk_ack[d] <= 1'b1;
                if (d == inj_disk && !dk_we) begin
                    dk_err[d] <= 1'b1;
                    inj_disk  <= -1;
                end else begin
                    dk_err[d] <= 1'b0;
                    if (dk_we) mem[d][dk_row[3:0]][dk_widx] <= dk_wdata;
                    else dk_rdata[d*W +: W] <= mem[d][dk_row[3:0]][dk_widx];
                end
            end else begin
                dk_ack[d] <= 1'b0;
                dk_err[d] <= 1'b0;
            end
        end
    end

    // Expected access stream, compared at every acknowledged access
    typedef struct {
        int disk;
        bit we;
        int row;
        int widx;
        int wdata;
    } acc_t;
    acc_t expq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < NK; d++) begin
                if (dk_ack[d]) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R3", "unexpected access on disk", d, -1);
                    end else begin
                        acc_t e;
                        e = expq.pop_front();
                        chk(d == e.disk, "R2", "access disk", d, e.disk);
                        chk(dk_we == e.we, "R3", "access direction", dk_we, e.we);
                        chk(int'(dk_row) == e.row, "R1", "access row", dk_row, e.row);
                        chk(int'(dk_widx) == e.widx, "R3", "access word index", dk_widx, e.widx);
                        if (e.we) chk(int'(dk_wdata) == e.wdata, "R4", "write word", dk_wdata, e.wdata);
                    end
                end
            end
        end
    end

    function automatic void map_lba(input int lba, output int row, output int dat, output int par);
        int k;
        row = lba / ND;
        k   = lba % ND;
        par = ND - (row % NK);
        dat = (k < par) ? k : k + 1;
    endfunction

    task automatic pulse_req(input bit we, input int lba, input logic [BW*W-1:0] blk);
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_lba   = LW'(lba);
        host_wdata = blk;
        @(negedge clk);
        host_req   = 1'b0;
    endtask

    task automatic wait_done(input string rq, output bit seen, output bit err_v,
                             output logic [BW*W-1:0] rd);
        seen = 1'b0;
        err_v = 1'b0;
        rd = '0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (host_done) begin
                seen = 1'b1;
                err_v = host_err;
                rd = host_rdata;
                chk(!host_busy, "R7", "busy low at completion", host_busy, 0);
            end else begin
                @(negedge clk);
            end
        end
        chk(seen, rq, "completion seen", seen, 1);
        @(negedge clk);
        chk(!host_done, "R8", "done lasts one cycle", host_done, 0);
    endtask

    task automatic do_write(input int lba, input logic [BW*W-1:0] blk, input bit poke_busy);
        int row, dat, par;
        bit seen, ev;
        logic [BW*W-1:0] rd;
        logic [W-1:0] newp [BW];
        map_lba(lba, row, dat, par);
        for (int w = 0; w < BW; w++) expq.push_back('{dat, 1'b0, row, w, 0});
        for (int w = 0; w < BW; w++) expq.push_back('{par, 1'b0, row, w, 0});
        for (int w = 0; w < BW; w++) expq.push_back('{dat, 1'b1, row, w, int'(blk[w*W +: W])});
        for (int w = 0; w < BW; w++) begin
            newp[w] = mem[par][row][w] ^ mem[dat][row][w] ^ blk[w*W +: W];
            expq.push_back('{par, 1'b1, row, w, int'(newp[w])});
        end
        pulse_req(1'b1, lba, blk);
        if (poke_busy) begin
            // R7: pulse a different request while busy; it must be ignored
            @(negedge clk);
            chk(host_busy, "R7", "busy after accept", host_busy, 1);
            pulse_req(1'b1, lba + 1, ~blk);
        end
        wait_done("R8", seen, ev, rd);
        chk(!ev, "R8", "write completes without error", ev, 0);
        chk(expq.size() == 0, "R3", "all four phases performed", expq.size(), 0);
        for (int w = 0; w < BW; w++) begin
            chk(mem[dat][row][w] == blk[w*W +: W], "R3", "stored data word", mem[dat][row][w], blk[w*W +: W]);
            chk(mem[par][row][w] == newp[w], "R4", "stored parity word", mem[par][row][w], newp[w]);
        end
        expq.delete();
    endtask

    task automatic do_read(input int lba);
        int row, dat, par;
        bit seen, ev;
        logic [BW*W-1:0] rd;
        map_lba(lba, row, dat, par);
        for (int w = 0; w < BW; w++) expq.push_back('{dat, 1'b0, row, w, 0});
        pulse_req(1'b0, lba, '0);
        wait_done("R5", seen, ev, rd);
        chk(!ev, "R5", "read completes without error", ev, 0);
        chk(expq.size() == 0, "R5", "only data-disk reads", expq.size(), 0);
        for (int w = 0; w < BW; w++)
            chk(rd[w*W +: W] == mem[dat][row][w], "R5", "read word", rd[w*W +: W], mem[dat][row][w]);
        expq.delete();
    endtask

    task automatic check_stripes();
        for (int r = 0; r < ROWS; r++) begin
            for (int w = 0; w < BW; w++) begin
                logic [W-1:0] x;
                x = '0;
                for (int d = 0; d < NK; d++) x = x ^ mem[d][r][w];
                chk(x == '0, "R4", "row parity consistent", x, 0);
            end
        end
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            int p;
            p = ND - (r % NK);
            for (int w = 0; w < BW; w++) begin
                logic [W-1:0] x;
                x = '0;
                for (int d = 0; d < NK; d++) begin
                    mem[d][r][w] = W'(d * 4099 + r * 131 + w * 7) ^ 16'h5a5a;
                    if (d != p) x = x ^ mem[d][r][w];
                end
                mem[p][r][w] = x;
            end
        end
    end

    initial begin : watchdog
        #2000000;
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        bit seen, ev;
        logic [BW*W-1:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk(!host_busy, "R10", "busy after reset", host_busy, 0);
        chk(!host_done, "R10", "done after reset", host_done, 0);
        chk(dk_req == '0, "R10", "disk requests after reset", dk_req, 0);

        // R1 R2: one write per stripe row, covering every parity position and a wrap
        do_write(0,  64'h1111_2222_3333_4444, 1'b0);
        do_write(5,  64'hdead_beef_0f0f_f0f0, 1'b0);
        do_write(11, 64'h0000_ffff_a5a5_5a5a, 1'b0);
        do_write(12, 64'h8001_4002_2004_1008, 1'b0);
        do_write(19, 64'h7777_0000_7777_0000, 1'b0);
        do_write(22, 64'hcafe_f00d_1234_5678, 1'b0);
        // R4: rewrite the same block so parity must use fresh old data
        do_write(5,  64'h0123_4567_89ab_cdef, 1'b0);
        // R7: request while busy ignored
        do_write(9,  64'hfeed_face_0bad_c0de, 1'b1);
        check_stripes();

        // R5: reads touch only the data disk
        do_read(5);
        do_read(22);
        do_read(30);

        // R9: fault on the parity read aborts before any write
        begin
            int row, dat, par;
            logic [W-1:0] keep [BW];
            map_lba(7, row, dat, par);
            for (int w = 0; w < BW; w++) keep[w] = mem[dat][row][w];
            for (int w = 0; w < BW; w++) expq.push_back('{dat, 1'b0, row, w, 0});
            expq.push_back('{par, 1'b0, row, 0, 0});
            inj_disk = par;
            pulse_req(1'b1, 7, 64'hbbbb_bbbb_bbbb_bbbb);
            wait_done("R9", seen, ev, rd);
            chk(ev, "R9", "error reported on completion", ev, 1);
            repeat (8) @(negedge clk);
            chk(dk_req == '0, "R9", "no request after abort", dk_req, 0);
            chk(expq.size() == 0, "R9", "access stream ended at fault", expq.size(), 0);
            for (int w = 0; w < BW; w++)
                chk(mem[dat][row][w] == keep[w], "R9", "data untouched after abort", mem[dat][row][w], keep[w]);
            expq.delete();
        end

        // recovery after abort
        do_write(7, 64'h5555_aaaa_5555_aaaa, 1'b0);
        check_stripes();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule